// File: doc/BRIEF.md
# Keypad Sequence Door Lock

This block is a clocked Moore controller for a two-key keypad. It accepts one key per clock as a presence flag plus two identity bits. It raises a single-cycle unlock pulse once the three-key code B, A, B has been entered. A 4-bit output reports how many keys of the current attempt have been taken, so a display decoder can show progress.

After a wrong key the controller moves onto an error path. That path keeps counting presses exactly as a correct entry would and falls back to idle after the third key. The display therefore gives no hint of which key was wrong.

The key inputs are assumed to be synchronous to the clock already. Debouncing, synchronizers and the display decoder sit outside this block.

Top module: `keypad_lock`

## Requirements
- R1: While `rst_ni` is low the controller is idle, with `unlock_o` = 0 and `count_o` = 0; this also holds when reset is applied in the middle of an entry.
- R2: The input code {`key_valid_i`, `key_a_i`, `key_b_i`} = 110 is key A and 101 is key B. Every other code (000, 001, 010, 011, 100, 111) is no key, and the state holds, except from the open state (see R6).
- R3: From idle, no key stays idle, key B goes to the first-correct state and key A goes to the first-error state.
- R4: From the first-correct state, no key holds, key A goes to the second-correct state and key B goes to the second-error state.
- R5: From the second-correct state, no key holds, key B goes to the open state and key A returns to idle.
- R6: The open state lasts exactly one cycle and returns to idle on any input, so `unlock_o` is a one-cycle pulse.
- R7: From the first-error state any key goes to the second-error state. From the second-error state any key returns to idle. Both error states hold on no key.
- R8: `count_o` depends only on the state: 0 in idle, 1 in the first-correct and first-error states, 2 in the second-correct and second-error states, and 3 in the open state.
- R9: `unlock_o` is high only in the open state. The unused state codes return to idle on the next clock with `unlock_o` low.
- R10: A valid key held for several cycles counts as one press per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_valid_i | input | 1 | A key is present this cycle |
| key_a_i | input | 1 | Key identity bit for A |
| key_b_i | input | 1 | Key identity bit for B |
| unlock_o | output | 1 | One-cycle unlock pulse |
| count_o | output | COUNT_W (4) | Keys taken in the current attempt |

## Verification
The properties assume that the key inputs change only between clock edges and that a legal press lasts one cycle per counted key. Under that assumption, an undecoded code outside the open state must leave both the state and the count untouched. The bench changes its inputs only on the falling edge. Its random draws cover all eight input codes, weighted toward the two legal keys, so that the good path and the error path are both reached often. The invalid codes still appear often enough to exercise the hold rule.

// File: rtl/keypad_lock_pkg.sv
package keypad_lock_pkg;
  localparam int STATE_W = 3;

  // codes 3'b110 and 3'b111 are unused
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'b000,
    ST_OK1  = 3'b001,
    ST_OK2  = 3'b010,
    ST_OPEN = 3'b011,
    ST_ERR1 = 3'b100,
    ST_ERR2 = 3'b101
  } lock_state_e;

  typedef enum logic [1:0] {
    KEY_NONE = 2'd0,
    KEY_A    = 2'd1,
    KEY_B    = 2'd2
  } key_e;
endpackage

// File: rtl/lock_key_decode.sv
module lock_key_decode
  import keypad_lock_pkg::*;
(
  input  logic key_valid_i,
  input  logic key_a_i,
  input  logic key_b_i,
  output key_e key_o
);
  always_comb begin
    unique case ({key_valid_i, key_a_i, key_b_i})
      3'b110:  key_o = KEY_A;
      3'b101:  key_o = KEY_B;
      default: key_o = KEY_NONE;
    endcase
  end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
  import keypad_lock_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  input  key_e               key_i,
  output logic [STATE_W-1:0] state_o
);
  always_comb begin
    state_o = state_i;
    case (state_i)
      ST_IDLE: begin
        if (key_i == KEY_B)      state_o = ST_OK1;
        else if (key_i == KEY_A) state_o = ST_ERR1;
      end
      ST_OK1: begin
        if (key_i == KEY_A)      state_o = ST_OK2;
        else if (key_i == KEY_B) state_o = ST_ERR2;
      end
      ST_OK2: begin
        if (key_i == KEY_B)      state_o = ST_OPEN;
        else if (key_i == KEY_A) state_o = ST_IDLE;
      end
      ST_OPEN: state_o = ST_IDLE;
      ST_ERR1: if (key_i != KEY_NONE) state_o = ST_ERR2;
      ST_ERR2: if (key_i != KEY_NONE) state_o = ST_IDLE;
      default: state_o = ST_IDLE;  // recover from unused codes
    endcase
  end
endmodule

// File: rtl/lock_out_decode.sv
module lock_out_decode
  import keypad_lock_pkg::*;
#(
  parameter int COUNT_W = 4
) (
  input  logic [STATE_W-1:0] state_i,
  output logic               unlock_o,
  output logic [COUNT_W-1:0] count_o
);
  logic [1:0] cnt;

  always_comb begin
    unlock_o = 1'b0;
    cnt      = 2'd0;
    case (state_i)
      ST_OK1, ST_ERR1: cnt = 2'd1;
      ST_OK2, ST_ERR2: cnt = 2'd2;
      ST_OPEN: begin
        cnt      = 2'd3;
        unlock_o = 1'b1;
      end
      default: cnt = 2'd0;
    endcase
  end

  assign count_o = COUNT_W'(cnt);
endmodule

// File: rtl/keypad_lock.sv
module keypad_lock
  import keypad_lock_pkg::*;
#(
  parameter int COUNT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               key_valid_i,
  input  logic               key_a_i,
  input  logic               key_b_i,
  output logic               unlock_o,
  output logic [COUNT_W-1:0] count_o
);
  key_e               key;
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;

  lock_key_decode u_dec (
    .key_valid_i(key_valid_i),
    .key_a_i    (key_a_i),
    .key_b_i    (key_b_i),
    .key_o      (key)
  );

  lock_next_state u_nxt (
    .state_i(state_q),
    .key_i  (key),
    .state_o(state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  lock_out_decode #(.COUNT_W(COUNT_W)) u_out (
    .state_i (state_q),
    .unlock_o(unlock_o),
    .count_o (count_o)
  );
endmodule

// File: rtl/keypad_lock_chk.sv
module keypad_lock_chk #(
  parameter int COUNT_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               key_valid_i,
  input logic               key_a_i,
  input logic               key_b_i,
  input logic               unlock_o,
  input logic [COUNT_W-1:0] count_o,
  input logic [2:0]         state_q
);
  logic press_a, press_b;
  assign press_a = key_valid_i & key_a_i & ~key_b_i;
  assign press_b = key_valid_i & ~key_a_i & key_b_i;

  assert_no_key_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!press_a && !press_b && !unlock_o && state_q < 3'd6)
      |=> ($stable(count_o) && $stable(state_q)));

  assert_open_needs_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlock_o) |-> $past(press_b));

  assert_one_cycle_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |=> (!unlock_o && count_o == '0));

  assert_count_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= COUNT_W'(3));

  assert_unlock_at_three_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |-> count_o == COUNT_W'(3));

  assert_unused_recover_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q >= 3'd6) |-> (!unlock_o ##1 state_q == 3'd0));
endmodule

bind keypad_lock keypad_lock_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .key_valid_i(key_valid_i),
  .key_a_i    (key_a_i),
  .key_b_i    (key_b_i),
  .unlock_o   (unlock_o),
  .count_o    (count_o),
  .state_q    (state_q)
);

// File: tb/keypad_lock_tb_top.sv
`timescale 1ns/1ps
module keypad_lock_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kv = 1'b0, ka = 1'b0, kb = 1'b0;
  logic       unlock;
  logic [3:0] cnt;
  int n_chk = 0, n_fail = 0;
  int m_st = 0;  // 0 idle,1 ok1,2 ok2,3 open,4 err1,5 err2

  always #2.5 clk = ~clk;

  keypad_lock dut_i (
    .clk_i(clk), .rst_ni(rst_n), .key_valid_i(kv), .key_a_i(ka), .key_b_i(kb),
    .unlock_o(unlock), .count_o(cnt)
  );

  function automatic int mdl_next(int s, logic v, logic a, logic b);
    logic is_a = v & a & ~b;
    logic is_b = v & ~a & b;
    case (s)
      0: return is_b ? 1 : (is_a ? 4 : 0);
      1: return is_a ? 2 : (is_b ? 5 : 1);
      2: return is_b ? 3 : (is_a ? 0 : 2);
      3: return 0;
      4: return (is_a || is_b) ? 5 : 4;
      5: return (is_a || is_b) ? 0 : 5;
      default: return 0;
    endcase
  endfunction

  function automatic int mdl_cnt(int s);
    case (s)
      1, 4: return 1;
      2, 5: return 2;
      3: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag);
    int  ec = mdl_cnt(m_st);
    logic eu = (m_st == 3);
    n_chk++;
    if (cnt !== 4'(ec) || unlock !== eu) begin
      n_fail++;
      $display("FAIL %s: count=%0d unlock=%b expected count=%0d unlock=%b",
               tag, cnt, unlock, ec, eu);
    end
  endtask

  task automatic step(logic v, logic a, logic b, string tag);
    kv = v; ka = a; kb = b;
    @(posedge clk);
    m_st = mdl_next(m_st, v, a, b);
    @(negedge clk);
    chk(tag);
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    chk("R1");
    rst_n = 1'b1;
    step(0, 0, 0, "R1");
    // password
    step(0, 0, 0, "R3");
    step(1, 0, 1, "R3");
    step(0, 0, 0, "R4");
    step(1, 1, 0, "R4");
    step(0, 0, 0, "R5");
    step(1, 0, 1, "R5");
    step(0, 0, 0, "R6");
    step(0, 0, 0, "R6");
    // open then key: still idle after one cycle
    step(1, 0, 1, "R3"); step(1, 1, 0, "R4"); step(1, 0, 1, "R5");
    step(1, 1, 0, "R6");
    // wrong second key
    step(1, 0, 1, "R3"); step(1, 0, 1, "R4"); step(0, 0, 0, "R7");
    step(1, 1, 0, "R7");
    // wrong third key
    step(1, 0, 1, "R3"); step(1, 1, 0, "R4"); step(1, 1, 0, "R5");
    // wrong first key, error path
    step(1, 1, 0, "R3"); step(0, 0, 0, "R7"); step(1, 0, 1, "R7");
    step(0, 0, 0, "R7"); step(1, 0, 1, "R7");
    // invalid codes hold in ok1
    step(1, 0, 1, "R3");
    for (int c = 0; c < 8; c++) begin
      if (c != 3'b110 && c != 3'b101 && c != 3'b000)
        step(c[2], c[1], c[0], "R2");
    end
    step(1, 1, 0, "R4");
    for (int c = 1; c < 5; c++) step(c[2], c[1], c[0], "R2");
    step(1, 0, 1, "R5");
    step(0, 0, 0, "R6");
    // held key
    step(1, 0, 1, "R10"); step(1, 0, 1, "R10"); step(1, 0, 1, "R10");
    // random
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      logic [2:0] code;
      if (r < 4)      code = 3'b110;
      else if (r < 8) code = 3'b101;
      else if (r == 8) code = 3'b000;
      else            code = 3'($urandom_range(0, 7));
      step(code[2], code[1], code[0], "R8 R9");
    end
    // reset mid-entry
    step(0, 0, 0, "R3");
    if (m_st != 0) step(1, 1, 0, "R8");
    if (m_st != 0) step(1, 1, 0, "R8");
    step(1, 0, 1, "R3"); step(1, 1, 0, "R4");
    kv = 0; ka = 0; kb = 0;
    rst_n = 1'b0;
    m_st = 0;
    #1;
    chk("R1");
    @(negedge clk);
    chk("R1");
    rst_n = 1'b1;
    step(0, 0, 0, "R1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule